// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares each source register named by the instruction in decode with the destination recorded in two older pipeline registers. The first of these is the execute-to-memory latch. The second is the memory-to-writeback latch. For every source operand it picks where the operand value must come from: the register file, the execute-to-memory latch, or the memory-to-writeback latch.

A result that is still in flight is normally bypassed, so it costs no cycles. The one exception is a load that is still in the execute-to-memory latch, because its data does not exist yet. When the decoding instruction reads that load's destination, the unit holds the program counter and the fetch/decode latch, and it injects a bubble into execute. The hazard clears by itself on the next cycle, when the load has moved into the memory-to-writeback latch and is bypassed from there. The block is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `hzu_bypass_unit`

## Requirements
- R1: A source operand with no matching latch gets select code 2'b00, which reads the register file.
- R2: A non-load in the execute-to-memory latch whose destination matches a source gives that operand code 2'b10 and causes no stall.
- R3: A match in the memory-to-writeback latch, whether the entry is a load or not, gives code 2'b01 and never causes a stall.
- R4: When both latches match the same source, code 2'b10 (the execute-to-memory latch) wins.
- R5: A load in the execute-to-memory latch whose destination matches either source raises pc_hold, ifid_hold and ex_bubble together.
- R6: A source or destination of register 0 never produces a match, so register 0 always reads the register file.
- R7: A latch entry whose write-enable is low is ignored by every comparison.
- R8: Each operand has its own 2-bit select in fwd_sel, with operand k in bits [2k+1:2k]. Each operand's select depends only on its own source number.
- R9: Once the stalling load has advanced into the memory-to-writeback latch, the stall drops and the operand selects code 2'b01.
- R10: A load in the execute-to-memory latch that matches no source causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src | input | NUM_SRC*5 | Source register numbers in decode; operand k is in bits [5k+4:5k] |
| exm_rd | input | 5 | Destination register held in the execute-to-memory latch |
| exm_wen | input | 1 | Execute-to-memory entry writes a register |
| exm_load | input | 1 | Execute-to-memory entry is a load |
| mwb_rd | input | 5 | Destination register held in the memory-to-writeback latch |
| mwb_wen | input | 1 | Memory-to-writeback entry writes a register |
| mwb_load | input | 1 | Memory-to-writeback entry is a load |
| fwd_sel | output | NUM_SRC*2 | Per-operand bypass select: 00 register file, 10 execute-to-memory, 01 memory-to-writeback |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| ex_bubble | output | 1 | Insert a bubble into the execute stage |

## Verification
The embedded assertions are checked on every input combination the pipeline presents. They cover the following:
- No select ever takes the unused code 2'b11.
- A stall always traces back to a load match in the execute-to-memory latch.
- The three stall outputs always agree.
- Register 0 and disabled entries never steer a select.
- A memory-to-writeback match alone never stalls.

The priority between latches, the exact code chosen for each operand pattern, and the independence of the two operands can only be shown by the bench's scenarios. The same holds for the two-cycle sequence in which a load first stalls the decoder and is then bypassed from the later latch.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    localparam int REG_AW = 5;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MWB     = 2'b01,
        SEL_EXM     = 2'b10
    } byp_sel_e;

    typedef struct packed {
        logic [REG_AW-1:0] rd;
        logic              wen;
        logic              is_load;
    } lat_dst_t;

    // True when a latch entry will write the register the source reads.
    function automatic logic dst_hits(lat_dst_t ent, logic [REG_AW-1:0] src);
        return ent.wen && (ent.rd != '0) && (ent.rd == src);
    endfunction

endpackage

// File: rtl/hzu_dst_cmp.sv
module hzu_dst_cmp
    import hzu_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  lat_dst_t          ent,
    output logic              hit
);

    always_comb begin
        hit = dst_hits(ent, src);
    end

endmodule

// File: rtl/hzu_sel_pick.sv
module hzu_sel_pick
    import hzu_pkg::*;
(
    input  logic     hit_exm,
    input  logic     hit_mwb,
    input  logic     exm_is_load,
    output byp_sel_e sel,
    output logic     load_wait
);

    // The younger result (execute-to-memory) wins over the older one.
    always_comb begin
        if (hit_exm)      sel = SEL_EXM;
        else if (hit_mwb) sel = SEL_MWB;
        else              sel = SEL_REGFILE;
        load_wait = hit_exm && exm_is_load;
    end

    always_comb begin
        a_r8_sel_legal: assert (sel != byp_sel_e'(2'b11))
            else $error("operand select took unused code");
        a_r3_mwb_no_wait: assert (!(hit_mwb && !hit_exm) || !load_wait)
            else $error("older-latch match requested a stall");
    end

endmodule

// File: rtl/hzu_stall_merge.sv
module hzu_stall_merge #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] waits,
    output logic               pc_hold,
    output logic               ifid_hold,
    output logic               ex_bubble
);

    logic any_wait;

    always_comb begin
        any_wait  = |waits;
        pc_hold   = any_wait;
        ifid_hold = any_wait;
        ex_bubble = any_wait;
    end

endmodule

// File: rtl/hzu_bypass_unit.sv
module hzu_bypass_unit
    import hzu_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]         exm_rd,
    input  logic                      exm_wen,
    input  logic                      exm_load,
    input  logic [REG_AW-1:0]         mwb_rd,
    input  logic                      mwb_wen,
    input  logic                      mwb_load,
    output logic [NUM_SRC*SEL_W-1:0]  fwd_sel,
    output logic                      pc_hold,
    output logic                      ifid_hold,
    output logic                      ex_bubble
);

    lat_dst_t           exm_ent;
    lat_dst_t           mwb_ent;
    logic [NUM_SRC-1:0] hit_exm;
    logic [NUM_SRC-1:0] hit_mwb;
    logic [NUM_SRC-1:0] waits;

    always_comb begin
        exm_ent = '{rd: exm_rd, wen: exm_wen, is_load: exm_load};
        mwb_ent = '{rd: mwb_rd, wen: mwb_wen, is_load: mwb_load};
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        logic [REG_AW-1:0] src_k;
        byp_sel_e          sel_k;

        assign src_k = id_src[k*REG_AW +: REG_AW];

        hzu_dst_cmp u_cmp_exm (
            .src (src_k),
            .ent (exm_ent),
            .hit (hit_exm[k])
        );

        hzu_dst_cmp u_cmp_mwb (
            .src (src_k),
            .ent (mwb_ent),
            .hit (hit_mwb[k])
        );

        hzu_sel_pick u_pick (
            .hit_exm     (hit_exm[k]),
            .hit_mwb     (hit_mwb[k]),
            .exm_is_load (exm_ent.is_load),
            .sel         (sel_k),
            .load_wait   (waits[k])
        );

        assign fwd_sel[k*SEL_W +: SEL_W] = sel_k;

        always_comb begin
            a_r6_zero_reads_rf: assert (src_k != '0 || sel_k == SEL_REGFILE)
                else $error("register 0 was bypassed");
            a_r7_disabled_ignored: assert (exm_wen || mwb_wen || sel_k == SEL_REGFILE)
                else $error("disabled entries steered a select");
        end
    end

    hzu_stall_merge #(.NUM_SRC(NUM_SRC)) u_stall (
        .waits     (waits),
        .pc_hold   (pc_hold),
        .ifid_hold (ifid_hold),
        .ex_bubble (ex_bubble)
    );

    always_comb begin
        a_r5_hold_agree: assert (pc_hold == ifid_hold && ifid_hold == ex_bubble)
            else $error("stall outputs disagree");
        a_r5_stall_needs_load: assert (!pc_hold || (exm_load && exm_wen && (|hit_exm)))
            else $error("stall without a matching load in execute-to-memory");
        a_r3_mwb_only_no_stall: assert (exm_wen || !pc_hold)
            else $error("stall raised with no execute-to-memory writer");
    end

endmodule

// File: tb/test_hzu_bypass_unit.sv
module test_hzu_bypass_unit;

    localparam int NSRC = 2;
    localparam int NV   = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NSRC*5-1:0] id_src;
    logic [4:0]        exm_rd, mwb_rd;
    logic              exm_wen, exm_load, mwb_wen, mwb_load;
    logic [NSRC*2-1:0] fwd_sel;
    logic              pc_hold, ifid_hold, ex_bubble;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    hzu_bypass_unit #(.NUM_SRC(NSRC)) i_hzu_bypass_unit (
        .id_src    (id_src),
        .exm_rd    (exm_rd),
        .exm_wen   (exm_wen),
        .exm_load  (exm_load),
        .mwb_rd    (mwb_rd),
        .mwb_wen   (mwb_wen),
        .mwb_load  (mwb_load),
        .fwd_sel   (fwd_sel),
        .pc_hold   (pc_hold),
        .ifid_hold (ifid_hold),
        .ex_bubble (ex_bubble)
    );

    // Fields: src a, src b, exm rd/wen/load, mwb rd/wen/load, exp sel a, exp sel b, exp stall
    localparam logic [28:0] VEC [NV] = '{
        {5'd1,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0},
        {5'd3,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b10, 2'b00, 1'b0},
        {5'd1,  5'd4,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b1, 2'b00, 2'b01, 1'b0},
        {5'd7,  5'd7,  5'd7,  1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 2'b10, 2'b10, 1'b0},
        {5'd5,  5'd1,  5'd5,  1'b1, 1'b1, 5'd9,  1'b1, 1'b0, 2'b10, 2'b00, 1'b1},
        {5'd1,  5'd5,  5'd5,  1'b1, 1'b1, 5'd9,  1'b1, 1'b0, 2'b00, 2'b10, 1'b1},
        {5'd5,  5'd1,  5'd8,  1'b1, 1'b0, 5'd5,  1'b1, 1'b1, 2'b01, 2'b00, 1'b0},
        {5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0},
        {5'd6,  5'd6,  5'd6,  1'b0, 1'b1, 5'd6,  1'b0, 1'b0, 2'b00, 2'b00, 1'b0},
        {5'd6,  5'd6,  5'd6,  1'b0, 1'b1, 5'd6,  1'b1, 1'b0, 2'b01, 2'b01, 1'b0},
        {5'd1,  5'd2,  5'd3,  1'b1, 1'b1, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0},
        {5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b10, 2'b01, 1'b0},
        {5'd31, 5'd31, 5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1, 2'b10, 2'b10, 1'b0},
        {5'd9,  5'd2,  5'd9,  1'b1, 1'b1, 5'd9,  1'b1, 1'b0, 2'b10, 2'b00, 1'b1}
    };
    localparam string TAG [NV] = '{"R1", "R2", "R3", "R4", "R5", "R5", "R9",
                                   "R6", "R7", "R7", "R10", "R8", "R4", "R5"};

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] er, input logic ew, input logic el,
                         input logic [4:0] mr, input logic mw, input logic ml);
        @(negedge clk);
        id_src   = {sb, sa};
        exm_rd   = er; exm_wen = ew; exm_load = el;
        mwb_rd   = mr; mwb_wen = mw; mwb_load = ml;
        #3;
    endtask

    // Checks both selects and the agreed stall level; all three hold pins must match.
    task automatic chk_all(input string tag, input logic [1:0] xa, input logic [1:0] xb,
                           input logic xs);
        chk(tag, {2'b00, fwd_sel[1:0]}, {2'b00, xa});
        chk(tag, {2'b00, fwd_sel[3:2]}, {2'b00, xb});
        chk(tag, {1'b0, pc_hold, ifid_hold, ex_bubble}, {1'b0, xs, xs, xs});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        id_src = '0; exm_rd = '0; exm_wen = 1'b0; exm_load = 1'b0;
        mwb_rd = '0; mwb_wen = 1'b0; mwb_load = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1 idle state: nothing in flight, everything reads the register file.
        @(negedge clk); #3;
        chk_all("R1", 2'b00, 2'b00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            drive(v[28:24], v[23:19], v[18:14], v[13], v[12], v[11:7], v[6], v[5]);
            chk_all(TAG[i], v[4:3], v[2:1], v[0]);
        end

        // R9: load stalls, then advances one stage and is bypassed from the later latch.
        drive(5'd12, 5'd3, 5'd12, 1'b1, 1'b1, 5'd20, 1'b1, 1'b0);
        chk_all("R9", 2'b10, 2'b00, 1'b1);
        drive(5'd12, 5'd3, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 1'b1);
        chk_all("R9", 2'b01, 2'b00, 1'b0);

        // R2 over every nonzero register: non-load match bypasses with no stall.
        for (int r = 1; r < 32; r++) begin
            drive(5'(r), 5'(r), 5'(r), 1'b1, 1'b0, 5'(r), 1'b0, 1'b0);
            chk_all("R2", 2'b10, 2'b10, 1'b0);
        end

        // R6: register 0 source against enabled zero destinations, load in execute-to-memory.
        drive(5'd0, 5'd14, 5'd0, 1'b1, 1'b1, 5'd14, 1'b1, 1'b0);
        chk_all("R6", 2'b00, 2'b01, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule